// File: doc/BRIEF.md
# Segment Offset Translator with Access Checks

This block takes one memory access per cycle and turns its segment-relative offset into a physical address. Each access comes with the cached descriptor of the segment it addresses: base, a 20-bit limit, a page-granularity flag, a downward-growing flag, a present flag, the descriptor privilege level and the accessed flag. It also comes with the privilege level the processor is running at and the requestor level taken from the selector.

The block checks presence first, then privilege, then bounds, and reports only the first failure as a 2-bit code. An access that fails a check produces no address. An access that passes produces the base plus the offset, with wrap-around. A passing access to a segment whose accessed flag is still clear also raises a request to set that flag. All results are registered. Every accepted request yields exactly one result on the following cycle.

Top module: `seg_xlate_top`

## Requirements
- R1: A clear present flag yields fault code 2'b01, whatever the privilege or bounds situation.
- R2: With the segment present, the effective level is the larger of the current level and the requestor level. If it is numerically greater than the descriptor level, the fault code is 2'b10, even when the offset is also out of bounds.
- R3: With page granularity set, the byte limit is (limit + 1) * 4096 - 1. Otherwise the limit is used as a byte limit as it stands.
- R4: For an upward segment, an offset above the byte limit gives fault code 2'b11. An offset equal to the limit passes.
- R5: For a downward segment, an offset at or below the byte limit gives fault code 2'b11. Any offset above it, up to 0xFFFFFFFF, passes.
- R6: A passing access raises rsp_ok and sets rsp_paddr to base + offset modulo 2^32, with fault code 2'b00.
- R7: rsp_set_acc rises with a passing result only when the descriptor's accessed flag was clear. It never rises on a fault.
- R8: Any fault holds rsp_ok low and rsp_paddr at zero.
- R9: Each request cycle gives rsp_valid exactly one cycle later. No result appears without a request. After reset, every output is zero.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_offset | input | 32 | Segment-relative offset |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | Limit counted in 4 KiB pages |
| desc_expdn | input | 1 | Segment grows downward |
| desc_present | input | 1 | Segment present in memory |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_accessed | input | 1 | Accessed flag as cached |
| cur_pl | input | 2 | Current privilege level |
| sel_rpl | input | 2 | Requestor privilege level of the selector |
| rsp_valid | output | 1 | A result is presented |
| rsp_ok | output | 1 | Access passed all checks |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 absent, 10 privilege, 11 bounds |
| rsp_set_acc | output | 1 | Request to set the accessed flag |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 20-bit limit and a 12-bit page shift. With these, the scaled page limit fills the address width exactly. This makes the 0xFFFFFFFF edge reachable for both limit forms, and it lets base-plus-offset wrap past 2^32. The vectors place offsets exactly at the limit and one past it, in both byte and page granularity. Other vectors stack several failing checks on one access to show the reporting order. Requests are issued back to back and also with idle gaps, so the one-cycle latency and the absence of stray results are both observed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PRIV   = 2'b10,
    FLT_BOUNDS = 2'b11
  } flt_e;
endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 32
) (
  input  logic [LIMIT_W-1:0] lim_raw,
  input  logic               page_gran,
  output logic [ADDR_W-1:0]  lim_bytes
);
  localparam int SCALED_W = LIMIT_W + PAGE_SHIFT;

  logic [SCALED_W-1:0] scaled;
  logic [ADDR_W-1:0]   page_lim;

  // (limit + 1) * page - 1 equals the limit with all page bits set below it
  assign scaled = {lim_raw, {PAGE_SHIFT{1'b1}}};

  generate
    if (SCALED_W > ADDR_W) begin : g_sat
      // Scaled limit wider than the address space: clamp to all ones
      assign page_lim = (|scaled[SCALED_W-1:ADDR_W]) ? {ADDR_W{1'b1}}
                                                    : scaled[ADDR_W-1:0];
    end else if (SCALED_W == ADDR_W) begin : g_fit
      assign page_lim = scaled;
    end else begin : g_ext
      assign page_lim = {{(ADDR_W-SCALED_W){1'b0}}, scaled};
    end
  endgenerate

  assign lim_bytes = page_gran ? page_lim
                               : {{(ADDR_W-LIMIT_W){1'b0}}, lim_raw};
endmodule

// File: rtl/seg_bounds_chk.sv
module seg_bounds_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] lim_bytes,
  input  logic              grows_down,
  output logic              out_of_range
);
  // The top of a downward segment is the largest offset the width can hold,
  // so the upper check of that form can never fail at this width.
  always_comb begin
    if (grows_down) out_of_range = (offset <= lim_bytes);
    else            out_of_range = (offset >  lim_bytes);
  end
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk #(
  parameter int PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] cur_pl,
  input  logic [PRIV_W-1:0] sel_rpl,
  input  logic [PRIV_W-1:0] dpl,
  output logic              denied
);
  logic [PRIV_W-1:0] eff_pl;
  assign eff_pl = (cur_pl > sel_rpl) ? cur_pl : sel_rpl;
  assign denied = (eff_pl > dpl);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int PRIV_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [LIMIT_W-1:0] desc_limit,
  input  logic              desc_gran,
  input  logic              desc_expdn,
  input  logic              desc_present,
  input  logic [PRIV_W-1:0] desc_dpl,
  input  logic              desc_accessed,
  input  logic [PRIV_W-1:0] cur_pl,
  input  logic [PRIV_W-1:0] sel_rpl,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              rsp_set_acc
);
  import seg_xlate_pkg::*;

  logic [ADDR_W-1:0] lim_bytes;
  logic              bounds_bad;
  logic              priv_bad;
  flt_e              flt_nxt;

  seg_limit_scale #(
    .LIMIT_W(LIMIT_W), .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)
  ) u_scale (
    .lim_raw(desc_limit), .page_gran(desc_gran), .lim_bytes(lim_bytes)
  );

  seg_bounds_chk #(.ADDR_W(ADDR_W)) u_bounds (
    .offset(req_offset), .lim_bytes(lim_bytes), .grows_down(desc_expdn),
    .out_of_range(bounds_bad)
  );

  seg_priv_chk #(.PRIV_W(PRIV_W)) u_priv (
    .cur_pl(cur_pl), .sel_rpl(sel_rpl), .dpl(desc_dpl), .denied(priv_bad)
  );

  // Fixed reporting order: presence, then privilege, then bounds
  always_comb begin
    if (!desc_present)   flt_nxt = FLT_ABSENT;
    else if (priv_bad)   flt_nxt = FLT_PRIV;
    else if (bounds_bad) flt_nxt = FLT_BOUNDS;
    else                 flt_nxt = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= FLT_NONE;
      rsp_set_acc <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault   <= flt_nxt;
        rsp_ok      <= (flt_nxt == FLT_NONE);
        rsp_paddr   <= (flt_nxt == FLT_NONE) ? (desc_base + req_offset) : '0;
        rsp_set_acc <= (flt_nxt == FLT_NONE) && !desc_accessed;
      end else begin
        rsp_fault   <= FLT_NONE;
        rsp_ok      <= 1'b0;
        rsp_paddr   <= '0;
        rsp_set_acc <= 1'b0;
      end
    end
  end

  // Absent segment reported first
  p_absent_first_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !desc_present |=> rsp_fault == FLT_ABSENT);

  // Requestor level alone above DPL is enough to deny
  p_rpl_denies_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && desc_present && (sel_rpl > desc_dpl) |=> rsp_fault == FLT_PRIV);

  p_set_acc_ok_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_set_acc |-> rsp_ok && rsp_valid);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_fault != FLT_NONE |-> !rsp_ok && rsp_paddr == '0);

  p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_stray_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/seg_xlate_top_test.sv
module seg_xlate_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_offset, desc_base;
  logic [19:0] desc_limit;
  logic        desc_gran, desc_expdn, desc_present, desc_accessed;
  logic [1:0]  desc_dpl, cur_pl, sel_rpl;
  logic        rsp_valid, rsp_ok, rsp_set_acc;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  typedef struct {
    int          cyc;
    string       tag;
    logic        ok;
    logic [31:0] paddr;
    logic [1:0]  fault;
    logic        set_acc;
  } exp_t;

  exp_t sb[$];
  int   cycle = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  seg_xlate_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
    .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
    .desc_expdn(desc_expdn), .desc_present(desc_present), .desc_dpl(desc_dpl),
    .desc_accessed(desc_accessed), .cur_pl(cur_pl), .sel_rpl(sel_rpl),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_set_acc(rsp_set_acc)
  );

  // Expected result computed from the requirements
  function automatic exp_t model(string tag, logic [31:0] off, logic [31:0] base,
                                 logic [19:0] lim, logic gran, logic ed, logic pres,
                                 logic [1:0] dpl, logic acc, logic [1:0] cpl,
                                 logic [1:0] rpl);
    exp_t e;
    logic [31:0] blim;
    logic [1:0]  eff;
    logic        oob;
    blim = gran ? {lim, 12'hFFF} : {12'h000, lim};
    eff  = (cpl > rpl) ? cpl : rpl;
    oob  = ed ? (off <= blim) : (off > blim);
    e.tag = tag;
    e.cyc = 0;
    if (!pres)          e.fault = 2'b01;
    else if (eff > dpl) e.fault = 2'b10;
    else if (oob)       e.fault = 2'b11;
    else                e.fault = 2'b00;
    e.ok      = (e.fault == 2'b00);
    e.paddr   = e.ok ? base + off : 32'h0;
    e.set_acc = e.ok && !acc;
    return e;
  endfunction

  task automatic issue(string tag, logic [31:0] off, logic [31:0] base,
                       logic [19:0] lim, logic gran, logic ed, logic pres,
                       logic [1:0] dpl, logic acc, logic [1:0] cpl, logic [1:0] rpl);
    exp_t e;
    @(negedge clk);
    e = model(tag, off, base, lim, gran, ed, pres, dpl, acc, cpl, rpl);
    e.cyc = cycle;
    sb.push_back(e);
    req_valid = 1'b1; req_offset = off; desc_base = base; desc_limit = lim;
    desc_gran = gran; desc_expdn = ed; desc_present = pres; desc_dpl = dpl;
    desc_accessed = acc; cur_pl = cpl; sel_rpl = rpl;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: each queued item must come back exactly one cycle after issue (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (sb.size() > 0 && sb[0].cyc + 1 == cycle) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (!rsp_valid || rsp_ok !== e.ok || rsp_paddr !== e.paddr ||
            rsp_fault !== e.fault || rsp_set_acc !== e.set_acc) begin
          n_bad++;
          $display("FAIL %s: got v=%0b ok=%0b pa=%h f=%0d acc=%0b, exp v=1 ok=%0b pa=%h f=%0d acc=%0b",
                   e.tag, rsp_valid, rsp_ok, rsp_paddr, rsp_fault, rsp_set_acc,
                   e.ok, e.paddr, e.fault, e.set_acc);
        end
      end else if (rsp_valid) begin
        n_chk++;
        n_bad++;
        $display("FAIL R9: stray result, got rsp_valid=1 exp 0");
      end
    end
  end

  initial begin
    fork
      begin
        rst = 1'b1; req_valid = 1'b0; req_offset = '0; desc_base = '0;
        desc_limit = '0; desc_gran = 0; desc_expdn = 0; desc_present = 0;
        desc_dpl = 0; desc_accessed = 0; cur_pl = 0; sel_rpl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 0 || rsp_ok !== 0 || rsp_paddr !== 0 ||
            rsp_fault !== 0 || rsp_set_acc !== 0) begin
          n_bad++;
          $display("FAIL R9: reset outputs v=%0b ok=%0b pa=%h f=%0d, exp all zero",
                   rsp_valid, rsp_ok, rsp_paddr, rsp_fault);
        end
        rst = 1'b0;
        // tag          off           base          lim      g  ed pr dpl acc cpl rpl
        issue("R6 basic",  32'h100,      32'h1000,     20'hFFFFF, 0, 0, 1, 3, 1, 0, 0);
        issue("R7 setacc", 32'h100,      32'h1000,     20'hFFFFF, 0, 0, 1, 3, 0, 0, 0);
        issue("R1 absent", 32'hFFFF_0000, 32'h0,       20'h10,    0, 0, 0, 0, 0, 3, 3);
        idle(2);
        issue("R2 cpl",    32'h9000,     32'h0,        20'h10,    0, 0, 1, 0, 0, 3, 0);
        issue("R2 rpl",    32'h0,        32'h0,        20'h10,    0, 0, 1, 2, 1, 0, 3);
        issue("R2 max ok", 32'h4,        32'h20,       20'h10,    0, 0, 1, 2, 1, 2, 1);
        issue("R4 at lim", 32'h10,       32'h0,        20'h10,    0, 0, 1, 3, 1, 0, 0);
        issue("R4 past",   32'h11,       32'h0,        20'h10,    0, 0, 1, 3, 1, 0, 0);
        idle(1);
        issue("R3 pg top", 32'hFFF,      32'h4000,     20'h0,     1, 0, 1, 3, 1, 0, 0);
        issue("R3 pg past",32'h1000,     32'h4000,     20'h0,     1, 0, 1, 3, 1, 0, 0);
        issue("R3 pg max", 32'hFFFF_FFFF, 32'h0,       20'hFFFFF, 1, 0, 1, 3, 1, 0, 0);
        issue("R3 byte",   32'h1000,     32'h0,        20'h0FFF,  0, 0, 1, 3, 1, 0, 0);
        issue("R5 at lim", 32'h1000,     32'h0,        20'h1000,  0, 1, 1, 3, 1, 0, 0);
        issue("R5 above",  32'h1001,     32'h100,      20'h1000,  0, 1, 1, 3, 0, 0, 0);
        issue("R5 top",    32'hFFFF_FFFF, 32'h0,       20'h1000,  0, 1, 1, 3, 1, 0, 0);
        issue("R5 pg low", 32'h1FFF,     32'h0,        20'h1,     1, 1, 1, 3, 1, 0, 0);
        issue("R6 wrap",   32'h2000,     32'hFFFF_F000, 20'hFFFFF, 1, 0, 1, 3, 1, 0, 0);
        issue("R8 R7 flt", 32'h50,       32'h1234,     20'h10,    0, 0, 1, 3, 0, 0, 0);
        idle(4);
        n_chk++;
        if (sb.size() != 0) begin
          n_bad++;
          $display("FAIL R9: %0d results missing, exp 0", sb.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9: watchdog expired, got hang exp completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule